// File: doc/BRIEF.md
# SD Host Register Compatibility Shim

The shim sits between a bus master that programs the standard SD host controller register layout and a controller core that places some bits elsewhere, expects certain fields merged, and has a few hardware quirks. Every host access is translated into zero, one, two or three core accesses. Reads are remapped on the way back. Writes are remapped, merged, masked, dropped or expanded into short sequences.

Both sides use a simple 32-bit register bus. Host writes carry their data on the byte lanes that the address and size select. The core side receives a word address, a per-bit write mask and data. Core reads return data combinationally in the same cycle. The host pulses `req_i` for one cycle while the shim is idle, then waits for the one-cycle `ready_o` pulse.

Top module: `sdshim_top`

## Requirements
- R1: A read of the interrupt status word (0x30) that returns bit 28 set from the core is returned to the host with bit 28 clear and bit 25 set. All other bits are unchanged.
- R2: A word write to interrupt enable (0x34) or signal enable (0x38) with bit 25 set reaches the core with bit 25 clear and bit 28 set.
- R3: A read of the capabilities word (0x40) with bit 20 set is returned with bit 20 clear and bit 19 set.
- R4: A halfword write to the transfer-mode register (0x0C) makes no core access. Its value is held in a scratch register, which is zero after reset.
- R5: A halfword write to the command register (0x0E) becomes one core write to word 0x0C with a full mask. The command halfword goes in bits 31:16 and the held transfer mode goes in bits 15:0.
- R6: When the command index (command bits 13:8) is 12, the command-type field (command bits 7:6, word bits 23:22) is forced to binary 11.
- R7: A halfword write to block size (0x04) reaches the core with bits 14:12 forced to zero, masked to bits 15:0.
- R8: A byte write to host control (0x28) becomes one core write with mask 0x0000FFF1. In the data, bit 0 is the written LED bit, bit 5 is forced to 1, written bits 4:3 move to bits 9:8, and every other bit is 0. This leaves bits 3:1 (bus width and resample bit) untouched.
- R9: A word write to 0x34 or 0x38 with bit 8 (card interrupt) set first produces two core writes to word 0x28 with mask 0x8: data 0x0, then data 0x8. The translated enable write follows them.
- R10: A byte write to power control (0x29) makes no core access and still completes.
- R11: A byte write to software reset (0x2F) with bit 24 set is forwarded and then followed by a core write to word 0x2C with mask 0x7 and data 0x7. When bit 24 is clear, only the forwarded write occurs.
- R12: Any other access passes through unchanged, with a lane mask taken from size (0 byte, 1 halfword, 2 or 3 word) and address. Reads make one core access. `ready_o` is high for exactly one cycle, N+1 cycles after the request, where N is the number of core accesses. After reset, `ready_o` and `core_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle host request pulse, accepted when idle |
| we_i | input | 1 | Host write (1) or read (0) |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| addr_i | input | 8 | Host byte address |
| wdata_i | input | 32 | Host write data on its byte lanes |
| rdata_o | output | 32 | Remapped read word, valid with ready_o |
| ready_o | output | 1 | Access complete pulse |
| core_req_o | output | 1 | Core access strobe |
| core_we_o | output | 1 | Core write (1) or read (0) |
| core_addr_o | output | 8 | Core word address |
| core_wmask_o | output | 32 | Per-bit write mask |
| core_wdata_o | output | 32 | Core write data |
| core_rdata_i | input | 32 | Core read data, same cycle |

## Verification
The richest collision is one interrupt-enable write that carries both the card-interrupt bit and the standard DMA-error bit. It has to produce the resample pulse pair and the remapped enable word within one access. The bench provokes it with 0x02000100 to word 0x34. The scoreboard then expects three core writes in exact order: clear resample, set resample, then the word with bit 28 set and bit 25 clear. Completion must come on the fourth cycle. A second pairing merges a stop command while a held transfer mode is pending. It is judged on the merged word, which must carry both the forced abort type and the held value.

// File: rtl/sdshim_pkg.sv
package sdshim_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int MAX_OPS = 3;
  localparam int OPS_W   = $clog2(MAX_OPS + 1);

  localparam logic [ADDR_W-1:0] A_BLKSZ  = 8'h04;
  localparam logic [ADDR_W-1:0] A_XFER   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CMD    = 8'h0E;
  localparam logic [ADDR_W-1:0] A_HCTL   = 8'h28;
  localparam logic [ADDR_W-1:0] A_PWR    = 8'h29;
  localparam logic [ADDR_W-1:0] A_SYSCTL = 8'h2C;
  localparam logic [ADDR_W-1:0] A_SWRST  = 8'h2F;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 8'h30;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h34;
  localparam logic [ADDR_W-1:0] A_SIGEN  = 8'h38;
  localparam logic [ADDR_W-1:0] A_CAPS   = 8'h40;

  localparam int BIT_STD_DMAERR = 25;
  localparam int BIT_VND_DMAERR = 28;
  localparam int BIT_CAP_ADMA1  = 20;
  localparam int BIT_CAP_ADMA2  = 19;
  localparam int BIT_CARD_INT   = 8;
  localparam int BIT_RESAMPLE   = 3;
  localparam int STOP_INDEX     = 12;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} acc_size_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } core_op_t;
endpackage

// File: rtl/sdshim_wr_xlate.sv
module sdshim_wr_xlate
  import sdshim_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  acc_size_e         size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [15:0]       scratch_i,
  output core_op_t          ops_o [MAX_OPS],
  output logic [OPS_W-1:0]  n_ops_o,
  output logic              scratch_we_o,
  output logic [15:0]       scratch_d_o
);
  localparam logic [DATA_W-1:0] ALL1 = '1;

  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] lmask;
  logic [15:0]       cmd;
  logic [15:0]       hc;
  logic [DATA_W-1:0] en_v;

  assign wa = {addr_i[ADDR_W-1:2], 2'b00};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: lmask = {{(DATA_W-8){1'b0}}, 8'hFF} << (8 * addr_i[1:0]);
      SZ_HALF: lmask = {{(DATA_W-16){1'b0}}, 16'hFFFF} << (addr_i[1] ? 16 : 0);
      default: lmask = ALL1;
    endcase
  end

  always_comb begin
    cmd = wdata_i[31:16];
    if (cmd[13:8] == 6'(STOP_INDEX)) cmd[7:6] = 2'b11;
    hc = '0;
    hc[0]   = wdata_i[0];
    hc[5]   = 1'b1;
    hc[9:8] = wdata_i[4:3];
    en_v = wdata_i;
    if (wdata_i[BIT_STD_DMAERR]) begin
      en_v[BIT_STD_DMAERR] = 1'b0;
      en_v[BIT_VND_DMAERR] = 1'b1;
    end
  end

  always_comb begin
    for (int k = 0; k < MAX_OPS; k++) ops_o[k] = '0;
    ops_o[0]     = '{addr: wa, mask: lmask, data: wdata_i};
    n_ops_o      = OPS_W'(1);
    scratch_we_o = 1'b0;
    scratch_d_o  = wdata_i[15:0];
    if (size_i == SZ_HALF && addr_i == A_XFER) begin
      n_ops_o      = '0;
      scratch_we_o = 1'b1;
    end else if (size_i == SZ_HALF && addr_i == A_CMD) begin
      ops_o[0] = '{addr: A_XFER, mask: ALL1, data: {cmd, scratch_i}};
    end else if (size_i == SZ_HALF && addr_i == A_BLKSZ) begin
      ops_o[0].data = wdata_i & ~32'h0000_7000;
    end else if (size_i == SZ_BYTE && addr_i == A_HCTL) begin
      ops_o[0] = '{addr: A_HCTL, mask: 32'h0000_FFF1, data: {16'h0, hc}};
    end else if (size_i == SZ_BYTE && addr_i == A_PWR) begin
      n_ops_o = '0;
    end else if (size_i == SZ_BYTE && addr_i == A_SWRST) begin
      if (wdata_i[24]) begin
        ops_o[1] = '{addr: A_SYSCTL, mask: 32'h7, data: 32'h7};
        n_ops_o  = OPS_W'(2);
      end
    end else if ((size_i == SZ_WORD || size_i == SZ_WORD2) &&
                 (addr_i == A_IEN || addr_i == A_SIGEN)) begin
      if (wdata_i[BIT_CARD_INT]) begin
        ops_o[0] = '{addr: A_HCTL, mask: 32'h8, data: 32'h0};
        ops_o[1] = '{addr: A_HCTL, mask: 32'h8, data: 32'h8};
        ops_o[2] = '{addr: wa, mask: ALL1, data: en_v};
        n_ops_o  = OPS_W'(3);
      end else begin
        ops_o[0] = '{addr: wa, mask: ALL1, data: en_v};
      end
    end
  end
endmodule

// File: rtl/sdshim_rd_xlate.sv
module sdshim_rd_xlate
  import sdshim_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = raw_i;
    if (addr_i == A_ISTAT && raw_i[BIT_VND_DMAERR]) begin
      data_o[BIT_VND_DMAERR] = 1'b0;
      data_o[BIT_STD_DMAERR] = 1'b1;
    end
    if (addr_i == A_CAPS && raw_i[BIT_CAP_ADMA1]) begin
      data_o[BIT_CAP_ADMA1] = 1'b0;
      data_o[BIT_CAP_ADMA2] = 1'b1;
    end
  end
endmodule

// File: rtl/sdshim_seq.sv
module sdshim_seq
  import sdshim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  core_op_t          ops_i [MAX_OPS],
  input  logic [OPS_W-1:0]  n_ops_i,
  input  logic [DATA_W-1:0] rd_remap_i,
  output logic              accept_o,
  output logic              core_req_o,
  output logic              core_we_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wmask_o,
  output logic [DATA_W-1:0] core_wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RESP} st_e;

  st_e               st_q;
  core_op_t          op_q [MAX_OPS];
  logic [OPS_W-1:0]  n_q, idx_q;
  logic              we_q;
  logic [DATA_W-1:0] rdata_q;
  logic [OPS_W-1:0]  n_eff;

  assign accept_o = (st_q == ST_IDLE) && req_i;
  assign n_eff    = we_i ? n_ops_i : OPS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      n_q     <= '0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
      for (int k = 0; k < MAX_OPS; k++) op_q[k] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          we_q  <= we_i;
          n_q   <= n_eff;
          idx_q <= '0;
          for (int k = 0; k < MAX_OPS; k++) op_q[k] <= ops_i[k];
          if (!we_i) op_q[0] <= '{addr: rd_addr_i, mask: '0, data: '0};
          st_q <= (n_eff == '0) ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: begin
          if (!we_q) rdata_q <= rd_remap_i;
          idx_q <= idx_q + OPS_W'(1);
          if (idx_q == n_q - OPS_W'(1)) st_q <= ST_RESP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    core_req_o   = (st_q == ST_ISSUE);
    core_we_o    = core_req_o && we_q;
    core_addr_o  = '0;
    core_wmask_o = '0;
    core_wdata_o = '0;
    for (int k = 0; k < MAX_OPS; k++) begin
      if (core_req_o && idx_q == OPS_W'(k)) begin
        core_addr_o  = op_q[k].addr;
        core_wmask_o = op_q[k].mask;
        core_wdata_o = op_q[k].data;
      end
    end
  end

  assign ready_o = (st_q == ST_RESP);
  assign rdata_o = rdata_q;

  assert_accept_progress_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (core_req_o || ready_o));
  assert_ready_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
endmodule

// File: rtl/sdshim_top.sv
module sdshim_top
  import sdshim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              core_req_o,
  output logic              core_we_o,
  output logic [ADDR_W-1:0] core_addr_o,
  output logic [DATA_W-1:0] core_wmask_o,
  output logic [DATA_W-1:0] core_wdata_o,
  input  logic [DATA_W-1:0] core_rdata_i
);
  core_op_t          ops [MAX_OPS];
  logic [OPS_W-1:0]  n_ops;
  logic              scr_we, accept;
  logic [15:0]       scr_d, scratch_q;
  logic [DATA_W-1:0] rd_remap;
  acc_size_e         size;

  assign size = acc_size_e'(size_i);

  sdshim_wr_xlate u_wr (
    .addr_i(addr_i), .size_i(size), .wdata_i(wdata_i), .scratch_i(scratch_q),
    .ops_o(ops), .n_ops_o(n_ops), .scratch_we_o(scr_we), .scratch_d_o(scr_d)
  );

  sdshim_rd_xlate u_rd (
    .addr_i(core_addr_o), .raw_i(core_rdata_i), .data_o(rd_remap)
  );

  sdshim_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .rd_addr_i({addr_i[ADDR_W-1:2], 2'b00}), .ops_i(ops), .n_ops_i(n_ops),
    .rd_remap_i(rd_remap), .accept_o(accept), .core_req_o(core_req_o),
    .core_we_o(core_we_o), .core_addr_o(core_addr_o), .core_wmask_o(core_wmask_o),
    .core_wdata_o(core_wdata_o), .rdata_o(rdata_o), .ready_o(ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       scratch_q <= '0;
    else if (accept && we_i && scr_we) scratch_q <= scr_d;
  end

  logic core_wr;
  assign core_wr = core_req_o && core_we_o;

  assert_xfer_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && we_i && size == SZ_HALF && addr_i == A_XFER) |=> !core_req_o);
  assert_stop_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr && core_addr_o == A_XFER && core_wmask_o[31:16] == 16'hFFFF &&
     core_wdata_o[29:24] == 6'(STOP_INDEX)) |-> core_wdata_o[23:22] == 2'b11);
  assert_blksz_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr && core_addr_o == A_BLKSZ && core_wmask_o[14:12] != 3'b0) |-> core_wdata_o[14:12] == 3'b0);
  assert_en_remap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr && (core_addr_o == A_IEN || core_addr_o == A_SIGEN)) |-> !core_wdata_o[BIT_STD_DMAERR]);
  assert_resample_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr && core_addr_o == A_HCTL && core_wmask_o == 32'h8 && !core_wdata_o[BIT_RESAMPLE])
    |=> (core_wr && core_addr_o == A_HCTL && core_wmask_o == 32'h8 && core_wdata_o[BIT_RESAMPLE]));
  assert_clk_restore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_wr && core_addr_o == A_SYSCTL && core_wmask_o[31:24] == 8'hFF && core_wdata_o[24])
    |=> (core_wr && core_addr_o == A_SYSCTL && core_wmask_o == 32'h7 && core_wdata_o == 32'h7));
endmodule

// File: tb/sdshim_top_bench.sv
module sdshim_top_bench;
  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] mask;
    logic [31:0] data;
  } exp_op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, core_rdata = '0;
  logic [31:0] rdata, core_wmask, core_wdata;
  logic [7:0]  core_addr;
  logic        ready, core_req, core_we;

  int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
  exp_op_t exp_q[$];

  always #10 clk = ~clk;

  sdshim_top u_sdshim_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .core_req_o(core_req), .core_we_o(core_we), .core_addr_o(core_addr),
    .core_wmask_o(core_wmask), .core_wdata_o(core_wdata), .core_rdata_i(core_rdata)
  );

  // monitor: pop and compare every core access
  always @(negedge clk) begin
    if (rst_n && core_req) begin
      mon_checks++;
      if (exp_q.size() == 0) begin
        mon_errs++;
        $display("FAIL R12 unexpected core op act=%0b/%h/%h/%h exp=none",
                 core_we, core_addr, core_wmask, core_wdata);
      end else begin
        exp_op_t e;
        e = exp_q.pop_front();
        if ({core_we, core_addr, core_wmask, core_wdata} !== e) begin
          mon_errs++;
          $display("FAIL core op act=%0b/%h/%h/%h exp=%0b/%h/%h/%h",
                   core_we, core_addr, core_wmask, core_wdata, e.we, e.addr, e.mask, e.data);
        end
      end
    end
  end

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [7:0] a, input logic [31:0] m, input logic [31:0] d);
    exp_q.push_back({w, a, m, d});
  endtask

  // drive one access; expect ready after n_ops+1 cycles
  task automatic access(input string tag, input logic w, input logic [1:0] s, input logic [7:0] a,
                        input logic [31:0] d, input int n_ops);
    int lat;
    @(negedge clk);
    req = 1'b1; we = w; size = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!ready && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check({tag, " latency"}, lat, n_ops + 1);
    check({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset ready", {31'b0, ready}, 0);
    check("R12 reset core_req", {31'b0, core_req}, 0);
    rst_n = 1'b1;

    // R5/R4: command before any transfer mode carries zero lower half
    push(1, 8'h0C, 32'hFFFF_FFFF, 32'h113A_0000);
    access("R5 cmd zero scratch", 1, 2'd1, 8'h0E, 32'h113A_0000, 1);
    // R4: transfer mode held
    access("R4 xfer held", 1, 2'd1, 8'h0C, 32'h0000_0025, 0);
    // R6 + R5: stop command merged with held value
    push(1, 8'h0C, 32'hFFFF_FFFF, 32'h0CDB_0025);
    access("R6 stop abort merge", 1, 2'd1, 8'h0E, 32'h0C1B_0000, 1);
    // R7 block size
    push(1, 8'h04, 32'h0000_FFFF, 32'h0000_0E00);
    access("R7 blksz", 1, 2'd1, 8'h04, 32'h0000_7E00, 1);
    // R12 block count halfword pass-through
    push(1, 8'h04, 32'hFFFF_0000, 32'h7777_0000);
    access("R12 half pass", 1, 2'd1, 8'h06, 32'h7777_0000, 1);
    // R8 host control
    push(1, 8'h28, 32'h0000_FFF1, 32'h0000_0321);
    access("R8 hctl ff", 1, 2'd0, 8'h28, 32'h0000_00FF, 1);
    push(1, 8'h28, 32'h0000_FFF1, 32'h0000_0120);
    access("R8 hctl 08", 1, 2'd0, 8'h28, 32'h0000_0008, 1);
    // R10 power dropped
    access("R10 pwr drop", 1, 2'd0, 8'h29, 32'h0000_0F00, 0);
    // R11 reset all, and reset without bit 24
    push(1, 8'h2C, 32'hFF00_0000, 32'h0100_0000);
    push(1, 8'h2C, 32'h0000_0007, 32'h0000_0007);
    access("R11 rst all", 1, 2'd0, 8'h2F, 32'h0100_0000, 2);
    push(1, 8'h2C, 32'hFF00_0000, 32'h0200_0000);
    access("R11 rst cmd only", 1, 2'd0, 8'h2F, 32'h0200_0000, 1);
    // R9 + R2 in one access
    push(1, 8'h28, 32'h0000_0008, 32'h0000_0000);
    push(1, 8'h28, 32'h0000_0008, 32'h0000_0008);
    push(1, 8'h34, 32'hFFFF_FFFF, 32'h1000_0100);
    access("R9 R2 card+dma", 1, 2'd2, 8'h34, 32'h0200_0100, 3);
    // R2 signal enable
    push(1, 8'h38, 32'hFFFF_FFFF, 32'h1000_0001);
    access("R2 sigen", 1, 2'd2, 8'h38, 32'h0200_0001, 1);
    // R12 word pass-through
    push(1, 8'h00, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    access("R12 word pass", 1, 2'd2, 8'h00, 32'hDEAD_BEEF, 1);
    // R1 status read
    core_rdata = 32'h1000_0003;
    push(0, 8'h30, 32'h0, 32'h0);
    access("R1 istat", 0, 2'd2, 8'h30, 32'h0, 1);
    check("R1 istat remap", rdata, 32'h0200_0003);
    core_rdata = 32'h0000_0001;
    push(0, 8'h30, 32'h0, 32'h0);
    access("R1 istat plain", 0, 2'd2, 8'h30, 32'h0, 1);
    check("R1 istat plain data", rdata, 32'h0000_0001);
    // R3 capabilities
    core_rdata = 32'h0010_0000;
    push(0, 8'h40, 32'h0, 32'h0);
    access("R3 caps", 0, 2'd2, 8'h40, 32'h0, 1);
    check("R3 caps remap", rdata, 32'h0008_0000);
    // R12 other read unchanged
    core_rdata = 32'h1010_0000;
    push(0, 8'h24, 32'h0, 32'h0);
    access("R12 read pass", 0, 2'd2, 8'h24, 32'h0, 1);
    check("R12 read pass data", rdata, 32'h1010_0000);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errs + mon_errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks + 1, errs + mon_errs + 1);
    $finish;
  end
endmodule